// File: doc/BRIEF.md
# Move-Elimination Reference Counter Table

This block keeps one small sharing counter for every physical register of the integer file. When rename eliminates a register-to-register move, the destination of the move is mapped onto the physical register already holding the source. Several logical registers then point at one physical register. Rename signals each such sharing through one of its increment lanes, and the counter of that register grows by one. The counter therefore holds the number of extra mappings beyond the first.

When a mapping goes away, the retirement side presents a release on one of its slots. At normal commit the released register is the old destination that the committing instruction displaced. During a walk, which undoes speculative work, it is the instruction's own physical destination. A release of a register whose counter is zero returns that register to the free pool. The pool notice appears on the same slot one cycle later. A release of a register with a non-zero counter only takes one reference away. A per-register saturation vector tells rename where sharing must be refused, and a flush drops every counter back to zero.

Top module: `mvelim_refcnt`

## Requirements
- R1: While reset is held, and after it is released, all counters are zero, every bit of `sat_o` is low and every bit of `free_valid_o` is low.
- R2: `sat_o[r]` is high exactly when the counter of register r holds its maximum value, 2^CNT_W-1 (three with the default two-bit counters). Only a valid increment lane naming r can raise it. A lane never names a register whose flag is high.
- R3: A release on slot s of a register whose counter is zero sets `free_valid_o[s]` one cycle later, with `free_preg_o[s]` equal to that register. A slot that carries no release reports no free.
- R4: A release of a register whose counter is non-zero decrements the counter and reports no free. A register shared by N eliminated moves is returned to the pool exactly once, on the N+1-th release.
- R5: When several slots release the same register in one cycle, the counter drops by the number of those slots. If that removes the last reference, a single free is reported, on the highest-numbered of those slots.
- R6: An increment and releases of the same register in one cycle are combined with the increment counted first, so the register is not freed while the new sharer still maps it.
- R7: While `walk_i` is high, the released register of each slot is `rel_own_preg_i`, not `rel_old_preg_i`.
- R8: During a walk, a release whose `rel_elim_i` bit is set never returns a register to the pool. It only removes a reference, and a zero counter stays at zero.
- R9: A flush clears every counter by the next cycle. Releases and increments presented in the flush cycle have no effect and report no free.
- R10: Up to LANES different registers can each be incremented in the same cycle, each by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| flush_i | input | 1 | Clears every counter; cancels this cycle's requests |
| walk_i | input | 1 | Releases name the instruction's own destination |
| inc_valid_i | input | LANES | Increment request per rename lane |
| inc_preg_i | input | LANES x IDX_W | Shared physical register per lane |
| rel_valid_i | input | SLOTS | Release request per retirement slot |
| rel_old_preg_i | input | SLOTS x IDX_W | Displaced destination, used at normal commit |
| rel_own_preg_i | input | SLOTS x IDX_W | Instruction's own destination, used in walk |
| rel_elim_i | input | SLOTS | Released instruction was an eliminated move |
| sat_o | output | NUM_PREGS | Counter at maximum, per physical register |
| free_valid_o | output | SLOTS | Register returned to the pool, per slot |
| free_preg_o | output | SLOTS x IDX_W | Register returned on that slot |

## Verification
Two functions of this block can meet on one register in a single cycle. One is a new sharer arriving through an increment lane while an old mapping of the same register retires. The other is two retirement slots releasing the same register together. Both are provoked by directed cycles that name the same register on a lane and on one or two slots at once. They are judged against a per-register reference count kept in the bench. The bench applies the increment first and then the releases in slot order, so the expected free either lands on the last slot or does not appear.

// File: rtl/mvelim_pkg.sv
// Package: shared helpers for the move-elimination reference counter table.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package mvelim_pkg;

    // Width needed to hold a count from 0 up to n inclusive.
    function automatic int unsigned count_width(input int unsigned n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/mvelim_target_sel.sv
// Module: picks the register each retirement slot releases, masks slots
// during a flush, and marks the highest-numbered slot naming each register.
// Assumes: walk_i is level-valid for the whole cycle.
module mvelim_target_sel #(
    parameter int SLOTS = 4,
    parameter int IDX_W = 5
) (
    input  logic                        flush_i,
    input  logic                        walk_i,
    input  logic [SLOTS-1:0]            rel_valid_i,
    input  logic [SLOTS-1:0][IDX_W-1:0] rel_old_preg_i,
    input  logic [SLOTS-1:0][IDX_W-1:0] rel_own_preg_i,
    input  logic [SLOTS-1:0]            rel_elim_i,
    output logic [SLOTS-1:0]            tgt_valid_o,
    output logic [SLOTS-1:0][IDX_W-1:0] tgt_preg_o,
    output logic [SLOTS-1:0]            tgt_elim_o,
    output logic [SLOTS-1:0]            tgt_last_o
);

    // Select the released register and qualify each slot.
    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            tgt_valid_o[s] = rel_valid_i[s] && !flush_i;
            tgt_preg_o[s]  = walk_i ? rel_own_preg_i[s] : rel_old_preg_i[s];
            tgt_elim_o[s]  = walk_i && rel_elim_i[s];
        end
    end

    // A slot is "last" when no younger slot names the same register.
    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            tgt_last_o[s] = 1'b1;
            for (int j = s + 1; j < SLOTS; j++) begin
                if (tgt_valid_o[j] && (tgt_preg_o[j] == tgt_preg_o[s]))
                    tgt_last_o[s] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/mvelim_count_cell.sv
// Module: reference counter of one physical register. Counts increments from
// the rename lanes and releases from the retirement slots, and reports
// saturation and whether this cycle's releases drop the last reference.
// Assumes: at most one lane names this register per cycle, no lane names it
// while saturated, and releases never exceed live references.
module mvelim_count_cell
    import mvelim_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int SLOTS  = 4,
    parameter int IDX_W  = 5,
    parameter int CNT_W  = 2,
    parameter int MY_IDX = 0
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        flush_i,
    input  logic [LANES-1:0]            inc_valid_i,
    input  logic [LANES-1:0][IDX_W-1:0] inc_preg_i,
    input  logic [SLOTS-1:0]            tgt_valid_i,
    input  logic [SLOTS-1:0][IDX_W-1:0] tgt_preg_i,
    input  logic [SLOTS-1:0]            tgt_elim_i,
    output logic                        sat_o,
    output logic                        dies_o
);

    localparam int HIT_W = int'(count_width(SLOTS));
    localparam int SUM_W = CNT_W + HIT_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [IDX_W-1:0] ME = IDX_W'(MY_IDX);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             inc_hit;
    logic             elim_hit;
    logic [HIT_W-1:0] hits;
    logic [SUM_W-1:0] total;   // extra references after this cycle's increment
    logic [SUM_W-1:0] live;    // all references after this cycle's increment
    logic [SUM_W-1:0] remain;

    // Detect an increment lane naming this register.
    always_comb begin
        inc_hit = 1'b0;
        for (int l = 0; l < LANES; l++)
            if (inc_valid_i[l] && (inc_preg_i[l] == ME)) inc_hit = 1'b1;
    end

    // Count releasing slots and note any walked eliminated move among them.
    always_comb begin
        hits     = '0;
        elim_hit = 1'b0;
        for (int s = 0; s < SLOTS; s++) begin
            if (tgt_valid_i[s] && (tgt_preg_i[s] == ME)) begin
                hits = hits + HIT_W'(1);
                if (tgt_elim_i[s]) elim_hit = 1'b1;
            end
        end
    end

    // Combine the increment first, then subtract the releases.
    always_comb begin
        total  = SUM_W'(cnt_q) + SUM_W'(inc_hit);
        live   = total + SUM_W'(1);
        dies_o = (hits != '0) && (SUM_W'(hits) == live) && !elim_hit;
        if (SUM_W'(hits) >= total) remain = '0;
        else                       remain = total - SUM_W'(hits);
        if (remain > SUM_W'(CNT_MAX)) cnt_d = CNT_MAX;
        else                          cnt_d = remain[CNT_W-1:0];
    end

    // Hold the counter; reset and flush clear it.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || flush_i) cnt_q <= '0;
        else                    cnt_q <= cnt_d;
    end

    assign sat_o = (cnt_q == CNT_MAX);

endmodule

// File: rtl/mvelim_free_stage.sv
// Module: registers the per-slot pool-return notices. A slot reports a free
// when it is the last slot naming a register whose last reference drops.
// Assumes: dies_i is indexed by physical register number.
module mvelim_free_stage #(
    parameter int NUM_PREGS = 32,
    parameter int SLOTS     = 4,
    parameter int IDX_W     = 5
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [SLOTS-1:0]            tgt_valid_i,
    input  logic [SLOTS-1:0][IDX_W-1:0] tgt_preg_i,
    input  logic [SLOTS-1:0]            tgt_last_i,
    input  logic [NUM_PREGS-1:0]        dies_i,
    output logic [SLOTS-1:0]            free_valid_o,
    output logic [SLOTS-1:0][IDX_W-1:0] free_preg_o
);

    logic [SLOTS-1:0] free_d;

    // Decide which slots hand a register back this cycle.
    always_comb begin
        for (int s = 0; s < SLOTS; s++)
            free_d[s] = tgt_valid_i[s] && tgt_last_i[s] && dies_i[tgt_preg_i[s]];
    end

    // Register the notices for the free pool.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            free_valid_o <= '0;
            free_preg_o  <= '0;
        end else begin
            free_valid_o <= free_d;
            free_preg_o  <= tgt_preg_i;
        end
    end

endmodule

// File: rtl/mvelim_refcnt.sv
// Module: per-physical-register reference counter table for move elimination.
// Rename raises a lane per eliminated move; retirement releases mappings.
// A register returns to the pool only when its last reference is released.
// Assumes: callers honour sat_o and never over-release a register.
module mvelim_refcnt #(
    parameter int NUM_PREGS = 32,
    parameter int LANES     = 4,
    parameter int SLOTS     = 4,
    parameter int CNT_W     = 2,
    localparam int IDX_W    = $clog2(NUM_PREGS)
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        flush_i,
    input  logic                        walk_i,
    input  logic [LANES-1:0]            inc_valid_i,
    input  logic [LANES-1:0][IDX_W-1:0] inc_preg_i,
    input  logic [SLOTS-1:0]            rel_valid_i,
    input  logic [SLOTS-1:0][IDX_W-1:0] rel_old_preg_i,
    input  logic [SLOTS-1:0][IDX_W-1:0] rel_own_preg_i,
    input  logic [SLOTS-1:0]            rel_elim_i,
    output logic [NUM_PREGS-1:0]        sat_o,
    output logic [SLOTS-1:0]            free_valid_o,
    output logic [SLOTS-1:0][IDX_W-1:0] free_preg_o
);

    logic [SLOTS-1:0]            tgt_valid;
    logic [SLOTS-1:0][IDX_W-1:0] tgt_preg;
    logic [SLOTS-1:0]            tgt_elim;
    logic [SLOTS-1:0]            tgt_last;
    logic [NUM_PREGS-1:0]        dies;

    mvelim_target_sel #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_sel (
        .flush_i        (flush_i),
        .walk_i         (walk_i),
        .rel_valid_i    (rel_valid_i),
        .rel_old_preg_i (rel_old_preg_i),
        .rel_own_preg_i (rel_own_preg_i),
        .rel_elim_i     (rel_elim_i),
        .tgt_valid_o    (tgt_valid),
        .tgt_preg_o     (tgt_preg),
        .tgt_elim_o     (tgt_elim),
        .tgt_last_o     (tgt_last)
    );

    for (genvar r = 0; r < NUM_PREGS; r++) begin : g_cell
        mvelim_count_cell #(
            .LANES (LANES),
            .SLOTS (SLOTS),
            .IDX_W (IDX_W),
            .CNT_W (CNT_W),
            .MY_IDX(r)
        ) u_cell (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .flush_i     (flush_i),
            .inc_valid_i (inc_valid_i & {LANES{!flush_i}}),
            .inc_preg_i  (inc_preg_i),
            .tgt_valid_i (tgt_valid),
            .tgt_preg_i  (tgt_preg),
            .tgt_elim_i  (tgt_elim),
            .sat_o       (sat_o[r]),
            .dies_o      (dies[r])
        );
    end

    mvelim_free_stage #(.NUM_PREGS(NUM_PREGS), .SLOTS(SLOTS), .IDX_W(IDX_W)) u_free (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tgt_valid_i  (tgt_valid),
        .tgt_preg_i   (tgt_preg),
        .tgt_last_i   (tgt_last),
        .dies_i       (dies),
        .free_valid_o (free_valid_o),
        .free_preg_o  (free_preg_o)
    );

endmodule

// File: rtl/mvelim_refcnt_chk.sv
// Module: property checker for mvelim_refcnt, attached by bind.
// Assumes: the same parameter values as the bound instance.
module mvelim_refcnt_chk #(
    parameter int NUM_PREGS = 32,
    parameter int LANES     = 4,
    parameter int SLOTS     = 4,
    parameter int IDX_W     = 5
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic                        flush_i,
    input logic                        walk_i,
    input logic [LANES-1:0]            inc_valid_i,
    input logic [LANES-1:0][IDX_W-1:0] inc_preg_i,
    input logic [SLOTS-1:0]            rel_valid_i,
    input logic [SLOTS-1:0]            rel_elim_i,
    input logic [NUM_PREGS-1:0]        sat_o,
    input logic [SLOTS-1:0]            free_valid_o,
    input logic [SLOTS-1:0][IDX_W-1:0] free_preg_o
);

    logic [NUM_PREGS-1:0] inc_any;

    // Which registers some lane names this cycle.
    always_comb begin
        inc_any = '0;
        for (int l = 0; l < LANES; l++)
            if (inc_valid_i[l]) inc_any[inc_preg_i[l]] = 1'b1;
    end

    AST_FLUSH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (sat_o == '0) && (free_valid_o == '0)); // R9

    for (genvar r = 0; r < NUM_PREGS; r++) begin : g_reg
        AST_SAT_NEEDS_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!sat_o[r] && !inc_any[r]) |=> !sat_o[r]); // R2
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        AST_NO_INC_ON_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            inc_valid_i[l] |-> !sat_o[inc_preg_i[l]]); // R2
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        AST_NO_STRAY_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !rel_valid_i[s] |=> !free_valid_o[s]); // R3
        AST_WALK_ELIM_NOFREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (walk_i && rel_valid_i[s] && rel_elim_i[s]) |=> !free_valid_o[s]); // R8
        for (genvar t = s + 1; t < SLOTS; t++) begin : g_pair
            AST_FREE_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (free_valid_o[s] && free_valid_o[t]) |-> (free_preg_o[s] != free_preg_o[t])); // R5
        end
    end

endmodule

bind mvelim_refcnt mvelim_refcnt_chk #(
    .NUM_PREGS(NUM_PREGS), .LANES(LANES), .SLOTS(SLOTS), .IDX_W(IDX_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .walk_i       (walk_i),
    .inc_valid_i  (inc_valid_i),
    .inc_preg_i   (inc_preg_i),
    .rel_valid_i  (rel_valid_i),
    .rel_elim_i   (rel_elim_i),
    .sat_o        (sat_o),
    .free_valid_o (free_valid_o),
    .free_preg_o  (free_preg_o)
);

// File: tb/mvelim_refcnt_bench.sv
// Bench: scoreboard for mvelim_refcnt. The driver keeps a reference count per
// register, pushes the expected pool notices of each cycle into a queue, and
// a monitor compares them once the registered outputs appear.
module mvelim_refcnt_bench;

    localparam int NUM_PREGS = 32;
    localparam int LANES     = 4;
    localparam int SLOTS     = 4;
    localparam int IDX_W     = 5;
    localparam int CNT_MAX   = 3;

    typedef struct {
        logic [SLOTS-1:0]            v;
        logic [SLOTS-1:0][IDX_W-1:0] p;
        int                          due;
        string                       req;
    } exp_t;

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic                        flush = 1'b0;
    logic                        walk = 1'b0;
    logic [LANES-1:0]            inc_v = '0;
    logic [LANES-1:0][IDX_W-1:0] inc_p = '0;
    logic [SLOTS-1:0]            rel_v = '0;
    logic [SLOTS-1:0][IDX_W-1:0] rel_old = '0;
    logic [SLOTS-1:0][IDX_W-1:0] rel_own = '0;
    logic [SLOTS-1:0]            rel_el = '0;
    logic [NUM_PREGS-1:0]        sat;
    logic [SLOTS-1:0]            fr_v;
    logic [SLOTS-1:0][IDX_W-1:0] fr_p;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   cyc      = 0;
    int   model [NUM_PREGS];
    exp_t sb [$];
    bit   done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    mvelim_refcnt u_mvelim_refcnt (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .flush_i        (flush),
        .walk_i         (walk),
        .inc_valid_i    (inc_v),
        .inc_preg_i     (inc_p),
        .rel_valid_i    (rel_v),
        .rel_old_preg_i (rel_old),
        .rel_own_preg_i (rel_own),
        .rel_elim_i     (rel_el),
        .sat_o          (sat),
        .free_valid_o   (fr_v),
        .free_preg_o    (fr_p)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare each expected item in the cycle it is due.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            bit   bad;
            e   = sb.pop_front();
            bad = (fr_v != e.v);
            for (int s = 0; s < SLOTS; s++)
                if (e.v[s] && fr_p[s] != e.p[s]) bad = 1'b1;
            n_checks++;
            if (bad) begin
                n_fail++;
                $display("FAIL %s: free valid=%b pregs=%h, expected valid=%b pregs=%h",
                         e.req, fr_v, fr_p, e.v, e.p);
            end
        end
    end

    task automatic clear_stim();
        flush = 1'b0; walk = 1'b0;
        inc_v = '0; inc_p = '0;
        rel_v = '0; rel_old = '0; rel_own = '0; rel_el = '0;
    endtask

    task automatic add_inc(input int lane, input int preg);
        inc_v[lane] = 1'b1;
        inc_p[lane] = IDX_W'(preg);
    endtask

    task automatic add_rel(input int slot, input int oldp, input int ownp, input bit el);
        rel_v[slot]   = 1'b1;
        rel_old[slot] = IDX_W'(oldp);
        rel_own[slot] = IDX_W'(ownp);
        rel_el[slot]  = el;
    endtask

    // Driver: apply the staged stimulus for one cycle and predict the frees.
    task automatic step(input string req);
        exp_t e;
        e.v = '0; e.p = '0; e.due = cyc + 1; e.req = req;
        if (flush) begin
            for (int r = 0; r < NUM_PREGS; r++) model[r] = 0;
        end else begin
            for (int l = 0; l < LANES; l++)
                if (inc_v[l]) model[inc_p[l]]++;
            for (int s = 0; s < SLOTS; s++) begin
                if (rel_v[s]) begin
                    int t;
                    t = walk ? int'(rel_own[s]) : int'(rel_old[s]);
                    if (model[t] == 0) begin
                        if (!(walk && rel_el[s])) begin
                            e.v[s] = 1'b1;
                            e.p[s] = IDX_W'(t);
                        end
                    end else begin
                        model[t]--;
                    end
                end
            end
        end
        sb.push_back(e);
        @(negedge clk);
        clear_stim();
    endtask

    task automatic check_sat(input string req, input logic [NUM_PREGS-1:0] expv);
        n_checks++;
        if (sat !== expv) begin
            n_fail++;
            $display("FAIL %s: sat=%h, expected %h", req, sat, expv);
        end
    endtask

    function automatic logic [NUM_PREGS-1:0] model_sat();
        logic [NUM_PREGS-1:0] m;
        for (int r = 0; r < NUM_PREGS; r++) m[r] = (model[r] == CNT_MAX);
        return m;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        for (int r = 0; r < NUM_PREGS; r++) model[r] = 0;
        clear_stim();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check_sat("R1 reset sat", '0);
        n_checks++;
        if (fr_v !== '0) begin
            n_fail++;
            $display("FAIL R1 reset free: %b, expected 0", fr_v);
        end
        rst_n = 1'b1;
        step("R1 idle after reset");
        check_sat("R1 after release", '0);

        // R3: unshared register returns at once
        add_rel(0, 5, 0, 1'b0); step("R3 plain release");
        step("R3 idle");

        // R4: register 7 shared by two moves needs three releases
        add_inc(0, 7); step("R4 share1");
        add_inc(1, 7); step("R4 share2");
        add_rel(1, 7, 0, 1'b0); step("R4 release1 no free");
        add_rel(3, 7, 0, 1'b0); step("R4 release2 no free");
        add_rel(2, 7, 0, 1'b0); step("R4 release3 frees");
        step("R4 idle");

        // R2: saturation of register 9
        add_inc(2, 9); step("R2 inc1");
        add_inc(3, 9); step("R2 inc2");
        check_sat("R2 below max", model_sat());
        add_inc(0, 9); step("R2 inc3");
        check_sat("R2 saturated", model_sat());
        add_rel(0, 9, 0, 1'b0); step("R2 release leaves max");
        check_sat("R2 desaturated", model_sat());

        // R5: two slots release register 10 holding one extra reference
        add_inc(1, 10); step("R5 share");
        add_rel(0, 10, 0, 1'b0); add_rel(2, 10, 0, 1'b0); step("R5 double release");
        add_rel(1, 11, 0, 1'b0); add_rel(3, 11, 0, 1'b0); add_inc(0, 11);
        step("R5 R6 double release with inc");

        // R6: increment and release of register 12 in one cycle
        add_inc(2, 12); add_rel(1, 12, 0, 1'b0); step("R6 inc with release");
        add_rel(0, 12, 0, 1'b0); step("R6 final release");

        // R7: walk releases own destination
        walk = 1'b1; add_rel(0, 3, 14, 1'b0); step("R7 walk own");
        // R8: walked eliminated move only drops a reference
        add_inc(3, 13); step("R8 share");
        walk = 1'b1; add_rel(1, 0, 13, 1'b1); step("R8 walk elim no free");
        walk = 1'b1; add_rel(2, 0, 15, 1'b1); step("R8 walk elim zero count");
        add_rel(0, 13, 0, 1'b0); step("R8 commit frees");

        // R10: four lanes, four registers, three cycles
        for (int k = 0; k < 3; k++) begin
            for (int l = 0; l < LANES; l++) add_inc(l, 20 + l);
            step("R10 parallel inc");
        end
        check_sat("R10 four saturated", model_sat());

        // R9: flush clears and cancels
        flush = 1'b1; add_rel(0, 21, 0, 1'b0); add_inc(0, 25); step("R9 flush");
        check_sat("R9 cleared", '0);
        add_rel(3, 20, 0, 1'b0); add_rel(0, 25, 0, 1'b0); step("R9 post-flush release");
        step("R9 idle");
        step("drain");
        finish_run();
    end

endmodule